// File: doc/BRIEF.md
# CAN Error-State Interrupt Flag Controller

This block follows a CAN node's fault-confinement state. It takes the receive and transmit error counts from the counter logic and reports whether the node is error-active, error-passive or bus-off. It raises three sticky interrupt flags: one on entry to error-passive, one on entry to bus-off, and one on recovery from bus-off. Each flag is raised on the entry edge and is not raised again while its condition persists. Software clears each flag with its own strobe.

While the node is bus-off, the block also runs the normal recovery sequence. It counts runs of eleven consecutive recessive bits, using strobes from the bit-timing logic, and recovery is complete after 128 such runs. Bus-off can also be left early, by selecting reset operating mode or by a forced-return request. Whether the recovery flag is raised depends on a 2-bit bus-off handling mode and on how the node left bus-off. In one mode the block asks for halt mode at bus-off entry. On any exit from bus-off it asks the counter logic to reset both counters.

Top module: `can_fault_flags`

## Requirements
- R1: `err_state` reads 2'b00 (error-active), 2'b01 (error-passive) or 2'b10 (bus-off), and never 2'b11. Outside bus-off it updates one clock after the counters change. It is 2'b01 when `rec` or `tec` is above 127 and `tec` is 255 or less, and 2'b00 when both counters are 127 or less.
- R2: `flag_ep` sets on the clock after the condition "`rec` > 127 or `tec` > 127" first becomes true.
- R3: If `flag_ep` is cleared while that condition still holds, it stays clear. It sets again only after both counters have been at 127 or below for at least one evaluated cycle and one of them then exceeds 127.
- R4: When `tec` (9 bits) goes above 255, `err_state` becomes 2'b10 and `flag_boe` sets on the same clock.
- R5: With `bo_mode` = 2'b01, bus-off entry also drives `halt_req` high for exactly one cycle, coinciding with `err_state` becoming 2'b10, and `flag_boe` still sets. With any other `bo_mode`, `halt_req` stays low.
- R6: Normal recovery completes on the strobe (`bit_strobe` = 1) that finishes the 128th run of 11 consecutive recessive bits (`bit_recessive` = 1). A dominant strobe restarts the current run. Both run counts are cleared on bus-off entry.
- R7: On normal recovery, `flag_bor` sets when `bo_mode` is 2'b00, 2'b10 or 2'b11. It never sets when `bo_mode` is 2'b01.
- R8: Bus-off is left at once, and `flag_bor` does not set, when `op_mode` = 2'b01 (reset) or `force_recover` = 1 is seen in bus-off. This holds even in the cycle in which normal recovery would complete.
- R9: With `bo_mode` = 2'b11, if `op_mode` = 2'b10 (halt) is seen at any time in bus-off, up to and including the completing cycle, `flag_bor` does not set on that recovery.
- R10: On any exit from bus-off, `err_state` returns to 2'b00 and `cnt_clr` pulses for one cycle. The counter inputs are ignored on the following clock.
- R11: Each flag holds until its clear strobe. A set event and a clear strobe on the same clock leave the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rec | input | 9 | Receive error count |
| tec | input | 9 | Transmit error count |
| bit_strobe | input | 1 | One-cycle strobe per sampled bus bit |
| bit_recessive | input | 1 | Level of the strobed bit, 1 = recessive |
| bo_mode | input | 2 | Bus-off handling mode |
| op_mode | input | 2 | Operating mode: 00 run, 01 reset, 10 halt |
| force_recover | input | 1 | Request to leave bus-off immediately |
| clr_ep | input | 1 | Clear strobe for the error-passive flag |
| clr_boe | input | 1 | Clear strobe for the bus-off entry flag |
| clr_bor | input | 1 | Clear strobe for the recovery flag |
| flag_ep | output | 1 | Error-passive entry flag |
| flag_boe | output | 1 | Bus-off entry flag |
| flag_bor | output | 1 | Bus-off recovery flag |
| err_state | output | 2 | Fault-confinement state |
| halt_req | output | 1 | One-cycle request to enter halt mode |
| cnt_clr | output | 1 | One-cycle request to reset both error counters |

## Verification
A wrong edge-detect memory shows up at the ports as a repeated or missing `flag_ep`, one clock after the counters cross the threshold. A recovery counter that is off by one shifts the exit from bus-off by at least one strobe. Because the recovery sequence is long, that error surfaces more than a thousand cycles after the fault. A halt-seen bit that is wrong stays hidden until the end of the recovery and then appears only as the value of `flag_bor`. For that reason every output is compared against a reference model on every clock, instead of only at the end of each scenario.

// File: rtl/canfc_pkg.sv
package canfc_pkg;

    typedef enum logic [1:0] {
        ST_ACTIVE  = 2'b00,
        ST_PASSIVE = 2'b01,
        ST_BUSOFF  = 2'b10
    } err_state_e;

    typedef enum logic [1:0] {
        BOM_PLAIN      = 2'b00,
        BOM_AUTO_HALT  = 2'b01,
        BOM_END_HALT   = 2'b10,
        BOM_SW_HALT    = 2'b11
    } bo_mode_e;

    localparam logic [1:0] OPM_RUN   = 2'b00;
    localparam logic [1:0] OPM_RESET = 2'b01;
    localparam logic [1:0] OPM_HALT  = 2'b10;

    localparam int FLG_EP  = 0;
    localparam int FLG_BOE = 1;
    localparam int FLG_BOR = 2;
    localparam int N_FLAGS = 3;

    // Recovery flag is allowed unless the mode suppresses it.
    function automatic logic bor_permitted(input logic [1:0] mode, input logic halted);
        return (mode != BOM_AUTO_HALT) && !((mode == BOM_SW_HALT) && halted);
    endfunction

endpackage

// File: rtl/canfc_recovery.sv
module canfc_recovery #(
    parameter int RUN_LEN   = 11,
    parameter int RUN_COUNT = 128
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic enable,
    input  logic bit_strobe,
    input  logic bit_recessive,
    output logic done
);
    localparam int RUN_W = $clog2(RUN_LEN + 1);
    localparam int OCC_W = $clog2(RUN_COUNT + 1);
    localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(RUN_LEN - 1);
    localparam logic [OCC_W-1:0] OCC_LAST = OCC_W'(RUN_COUNT - 1);

    logic [RUN_W-1:0] run_q;
    logic [OCC_W-1:0] occ_q;
    logic             run_end;

    assign run_end = enable && bit_strobe && bit_recessive && (run_q == RUN_LAST);
    assign done    = run_end && (occ_q == OCC_LAST);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            run_q <= '0;
            occ_q <= '0;
        end else if (enable && bit_strobe) begin
            if (!bit_recessive) begin
                run_q <= '0;
            end else if (run_end) begin
                run_q <= '0;
                occ_q <= done ? '0 : occ_q + OCC_W'(1);
            end else begin
                run_q <= run_q + RUN_W'(1);
            end
        end
    end

    // R6: run length and run tally stay inside their ranges
    a_r6_run_bound: assert property (@(posedge clk) disable iff (rst)
        run_q <= RUN_LAST);
    a_r6_occ_bound: assert property (@(posedge clk) disable iff (rst)
        occ_q <= OCC_LAST);
    // R6: a dominant strobe restarts the run
    a_r6_dominant_restart: assert property (@(posedge clk) disable iff (rst)
        (enable && bit_strobe && !bit_recessive && !clear) |=> (run_q == '0));

endmodule

// File: rtl/canfc_state_track.sv
module canfc_state_track
    import canfc_pkg::*;
#(
    parameter int CNT_W         = 9,
    parameter int PASSIVE_LIMIT = 127,
    parameter int BUSOFF_LIMIT  = 255
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [CNT_W-1:0]   rec,
    input  logic [CNT_W-1:0]   tec,
    input  logic [1:0]         bo_mode,
    input  logic [1:0]         op_mode,
    input  logic               force_recover,
    input  logic               rec_done,
    output err_state_e         state,
    output logic [N_FLAGS-1:0] events,
    output logic               bo_enter,
    output logic               in_busoff,
    output logic               halt_req,
    output logic               cnt_clr
);
    localparam logic [CNT_W-1:0] PASS_TH = CNT_W'(PASSIVE_LIMIT);
    localparam logic [CNT_W-1:0] BOFF_TH = CNT_W'(BUSOFF_LIMIT);

    err_state_e state_q;
    logic over_q, blank_q, halted_q, halt_req_q, cnt_clr_q;
    logic over_now, bo_now, forced_exit, normal_exit, evaluate;

    assign over_now    = (rec > PASS_TH) || (tec > PASS_TH);
    assign bo_now      = tec > BOFF_TH;
    assign in_busoff   = (state_q == ST_BUSOFF);
    assign evaluate    = !in_busoff && !blank_q;
    assign forced_exit = in_busoff && ((op_mode == OPM_RESET) || force_recover);
    assign normal_exit = in_busoff && !forced_exit && rec_done;
    assign bo_enter    = evaluate && bo_now;

    always_comb begin
        events          = '0;
        events[FLG_EP]  = evaluate && over_now && !over_q;
        events[FLG_BOE] = bo_enter;
        events[FLG_BOR] = normal_exit &&
                          bor_permitted(bo_mode, halted_q || (op_mode == OPM_HALT));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_ACTIVE;
            over_q     <= 1'b0;
            blank_q    <= 1'b0;
            halted_q   <= 1'b0;
            halt_req_q <= 1'b0;
            cnt_clr_q  <= 1'b0;
        end else begin
            halt_req_q <= 1'b0;
            cnt_clr_q  <= 1'b0;
            blank_q    <= 1'b0;
            if (in_busoff) begin
                if (op_mode == OPM_HALT) halted_q <= 1'b1;
                if (forced_exit || normal_exit) begin
                    state_q   <= ST_ACTIVE;
                    over_q    <= 1'b0;
                    blank_q   <= 1'b1;
                    cnt_clr_q <= 1'b1;
                end
            end else if (!blank_q) begin
                over_q <= over_now;
                if (bo_now) begin
                    state_q    <= ST_BUSOFF;
                    halted_q   <= 1'b0;
                    halt_req_q <= (bo_mode == BOM_AUTO_HALT);
                end else begin
                    state_q <= over_now ? ST_PASSIVE : ST_ACTIVE;
                end
            end
        end
    end

    assign state    = state_q;
    assign halt_req = halt_req_q;
    assign cnt_clr  = cnt_clr_q;

    // R1: unused encoding never reached
    a_r1_legal_state: assert property (@(posedge clk) disable iff (rst)
        state_q != err_state_e'(2'b11));
    // R5: halt request only accompanies bus-off
    a_r5_halt_in_busoff: assert property (@(posedge clk) disable iff (rst)
        halt_req_q |-> (state_q == ST_BUSOFF));
    // R10: counter-reset pulse only right after leaving bus-off
    a_r10_exit_to_active: assert property (@(posedge clk) disable iff (rst)
        cnt_clr_q |-> (state_q == ST_ACTIVE && $past(state_q) == ST_BUSOFF));

endmodule

// File: rtl/canfc_flag_bank.sv
module canfc_flag_bank #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] q
);
    for (genvar g = 0; g < N; g++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst) q[g] <= 1'b0;
            else     q[g] <= set[g] | (q[g] & ~clr[g]);
        end

        // R11: a flag without a clear strobe holds
        a_r11_flag_hold: assert property (@(posedge clk) disable iff (rst)
            (q[g] && !clr[g]) |=> q[g]);
        // R11: set wins over clear
        a_r11_set_wins: assert property (@(posedge clk) disable iff (rst)
            set[g] |=> q[g]);
    end
endmodule

// File: rtl/can_fault_flags.sv
module can_fault_flags
    import canfc_pkg::*;
#(
    parameter int CNT_W         = 9,
    parameter int PASSIVE_LIMIT = 127,
    parameter int BUSOFF_LIMIT  = 255,
    parameter int RUN_LEN       = 11,
    parameter int RUN_COUNT     = 128
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] rec,
    input  logic [CNT_W-1:0] tec,
    input  logic             bit_strobe,
    input  logic             bit_recessive,
    input  logic [1:0]       bo_mode,
    input  logic [1:0]       op_mode,
    input  logic             force_recover,
    input  logic             clr_ep,
    input  logic             clr_boe,
    input  logic             clr_bor,
    output logic             flag_ep,
    output logic             flag_boe,
    output logic             flag_bor,
    output logic [1:0]       err_state,
    output logic             halt_req,
    output logic             cnt_clr
);
    err_state_e         st;
    logic [N_FLAGS-1:0] ev, clr_v, flags;
    logic               bo_enter, in_bo, rec_done;

    canfc_state_track #(
        .CNT_W(CNT_W), .PASSIVE_LIMIT(PASSIVE_LIMIT), .BUSOFF_LIMIT(BUSOFF_LIMIT)
    ) u_track (
        .clk(clk), .rst(rst), .rec(rec), .tec(tec),
        .bo_mode(bo_mode), .op_mode(op_mode), .force_recover(force_recover),
        .rec_done(rec_done), .state(st), .events(ev), .bo_enter(bo_enter),
        .in_busoff(in_bo), .halt_req(halt_req), .cnt_clr(cnt_clr)
    );

    canfc_recovery #(.RUN_LEN(RUN_LEN), .RUN_COUNT(RUN_COUNT)) u_recov (
        .clk(clk), .rst(rst), .clear(bo_enter), .enable(in_bo),
        .bit_strobe(bit_strobe), .bit_recessive(bit_recessive), .done(rec_done)
    );

    always_comb begin
        clr_v          = '0;
        clr_v[FLG_EP]  = clr_ep;
        clr_v[FLG_BOE] = clr_boe;
        clr_v[FLG_BOR] = clr_bor;
    end

    canfc_flag_bank #(.N(N_FLAGS)) u_flags (
        .clk(clk), .rst(rst), .set(ev), .clr(clr_v), .q(flags)
    );

    assign flag_ep   = flags[FLG_EP];
    assign flag_boe  = flags[FLG_BOE];
    assign flag_bor  = flags[FLG_BOR];
    assign err_state = st;

    // R4: entering bus-off is always accompanied by the entry flag
    a_r4_boe_on_entry: assert property (@(posedge clk) disable iff (rst)
        (err_state == 2'b10 && $past(err_state) != 2'b10) |-> flag_boe);
    // R8: a forced return never raises the recovery flag
    a_r8_forced_no_bor: assert property (@(posedge clk) disable iff (rst)
        (err_state == 2'b10 && (force_recover || op_mode == OPM_RESET) && !flag_bor)
        |=> !flag_bor);
    // R9: halt seen in software-halt mode keeps the recovery flag clear
    a_r9_halt_blocks_bor: assert property (@(posedge clk) disable iff (rst)
        (err_state == 2'b10 && bo_mode == 2'b11 && op_mode == OPM_HALT && !flag_bor)
        |=> !flag_bor);
    // R7: recovery flag never set in auto-halt mode
    a_r7_no_bor_auto_halt: assert property (@(posedge clk) disable iff (rst)
        (err_state == 2'b10 && bo_mode == 2'b01 && !flag_bor) |=> !flag_bor);

endmodule

// File: tb/sim_can_fault_flags.sv
`timescale 1ns/1ps
module sim_can_fault_flags;
    localparam int RUNS = 128;
    localparam int RLEN = 11;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [8:0] rec = '0, tec = '0;
    logic bit_strobe = 1'b0, bit_recessive = 1'b0;
    logic [1:0] bo_mode = 2'b00, op_mode = 2'b00;
    logic force_recover = 1'b0, clr_ep = 1'b0, clr_boe = 1'b0, clr_bor = 1'b0;
    logic flag_ep, flag_boe, flag_bor, halt_req, cnt_clr;
    logic [1:0] err_state;

    int n_cmp = 0, n_bad = 0;
    bit go = 1'b0;

    always #5 clk = ~clk;

    can_fault_flags u0 (
        .clk(clk), .rst(rst), .rec(rec), .tec(tec), .bit_strobe(bit_strobe),
        .bit_recessive(bit_recessive), .bo_mode(bo_mode), .op_mode(op_mode),
        .force_recover(force_recover), .clr_ep(clr_ep), .clr_boe(clr_boe),
        .clr_bor(clr_bor), .flag_ep(flag_ep), .flag_boe(flag_boe),
        .flag_bor(flag_bor), .err_state(err_state), .halt_req(halt_req),
        .cnt_clr(cnt_clr)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural reference model
    int m_state = 0, m_run = 0, m_occ = 0;
    bit m_over = 0, m_blank = 0, m_hs = 0;
    bit m_ep = 0, m_boe = 0, m_bor = 0, m_halt = 0, m_cclr = 0;

    always @(posedge clk) begin
        bit e_ep, e_boe, e_bor, leave, overc;
        e_ep = 0; e_boe = 0; e_bor = 0; leave = 0;
        if (rst) begin
            m_state = 0; m_run = 0; m_occ = 0; m_over = 0; m_blank = 0; m_hs = 0;
            m_ep = 0; m_boe = 0; m_bor = 0; m_halt = 0; m_cclr = 0;
        end else begin
            m_halt = 0; m_cclr = 0;
            if (m_state == 2) begin
                if (op_mode == 2'b01 || force_recover) begin
                    leave = 1;
                end else if (bit_strobe) begin
                    if (!bit_recessive) m_run = 0;
                    else if (m_run == RLEN - 1) begin
                        m_run = 0;
                        if (m_occ == RUNS - 1) begin
                            leave = 1;
                            e_bor = (bo_mode != 2'b01) &&
                                    !(bo_mode == 2'b11 && (m_hs || op_mode == 2'b10));
                        end else m_occ++;
                    end else m_run++;
                end
                if (op_mode == 2'b10) m_hs = 1;
                if (leave) begin
                    m_state = 0; m_over = 0; m_blank = 1; m_cclr = 1;
                end
            end else if (m_blank) begin
                m_blank = 0;
            end else begin
                overc = (rec > 127) || (tec > 127);
                e_ep = overc && !m_over;
                m_over = overc;
                if (tec > 255) begin
                    m_state = 2; e_boe = 1; m_run = 0; m_occ = 0; m_hs = 0;
                    m_halt = (bo_mode == 2'b01);
                end else m_state = overc ? 1 : 0;
            end
            m_ep  = e_ep  || (m_ep  && !clr_ep);
            m_boe = e_boe || (m_boe && !clr_boe);
            m_bor = e_bor || (m_bor && !clr_bor);
        end
    end

    // Per-clock comparison, away from the active edge
    always @(negedge clk) begin
        if (go) begin
            chk("R1 err_state", int'(err_state), m_state);
            chk("R2 flag_ep", int'(flag_ep), int'(m_ep));
            chk("R4 flag_boe", int'(flag_boe), int'(m_boe));
            chk("R7 flag_bor", int'(flag_bor), int'(m_bor));
            chk("R5 halt_req", int'(halt_req), int'(m_halt));
            chk("R10 cnt_clr", int'(cnt_clr), int'(m_cclr));
        end
    end

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clear_all();
        clr_ep = 1; clr_boe = 1; clr_bor = 1;
        tick();
        clr_ep = 0; clr_boe = 0; clr_bor = 0;
    endtask

    task automatic enter_busoff(input logic [1:0] mode);
        bo_mode = mode; tec = 9'd256;
        tick();
    endtask

    // Full normal recovery; optionally force on the completing strobe
    task automatic recover(input bit force_last);
        bit_strobe = 1; bit_recessive = 1;
        for (int i = 0; i < RUNS * RLEN; i++) begin
            if (i == RUNS * RLEN - 1) begin
                chk("R6 still bus-off before last run", int'(err_state), 2);
                force_recover = force_last;
            end
            tick();
        end
        bit_strobe = 0; force_recover = 0; rec = 0; tec = 0;
    endtask

    initial begin
        @(negedge clk);
        tick(); tick();
        rst = 0;
        tick();
        go = 1;
        chk("R1 reset state", int'(err_state), 0);
        chk("R11 reset flags", int'({flag_ep, flag_boe, flag_bor}), 0);

        // R1 / R2: passive entry via REC
        rec = 9'd100; tick();
        chk("R1 active below limit", int'(err_state), 0);
        rec = 9'd128; tick();
        chk("R1 passive", int'(err_state), 1);
        chk("R2 ep set on first crossing", int'(flag_ep), 1);
        // R3: clear while still above -> stays clear
        clr_ep = 1; tick(); clr_ep = 0;
        chk("R3 ep cleared", int'(flag_ep), 0);
        rec = 9'd200; tick(); tick();
        chk("R3 no re-arm while above", int'(flag_ep), 0);
        tec = 9'd130; rec = 9'd0; tick();
        chk("R3 no re-arm via other counter", int'(flag_ep), 0);
        tec = 9'd127; tick();
        chk("R1 back to active at 127", int'(err_state), 0);
        tec = 9'd128; tick();
        chk("R3 re-armed after dropping", int'(flag_ep), 1);
        // R11: set and clear on the same clock
        tec = 0; clr_ep = 1; tick(); clr_ep = 0;
        chk("R11 cleared", int'(flag_ep), 0);
        rec = 9'd140; clr_ep = 1; tick(); clr_ep = 0;
        chk("R11 set wins over clear", int'(flag_ep), 1);
        rec = 0; tick(); clear_all();

        // R4 / R6 / R7: mode 00, interrupted run then normal recovery
        enter_busoff(2'b00);
        chk("R4 bus-off state", int'(err_state), 2);
        chk("R4 boe set", int'(flag_boe), 1);
        chk("R5 no halt in mode 00", int'(halt_req), 0);
        bit_strobe = 1; bit_recessive = 1;
        repeat (5) tick();
        bit_recessive = 0; tick();
        recover(1'b0);
        chk("R7 bor set mode 00", int'(flag_bor), 1);
        chk("R10 state active after exit", int'(err_state), 0);
        chk("R10 counter reset pulse", int'(cnt_clr), 1);
        tick(); tick(); clear_all();

        // R5 / R7: mode 01
        enter_busoff(2'b01);
        chk("R5 halt pulse", int'(halt_req), 1);
        chk("R5 boe set", int'(flag_boe), 1);
        tick();
        chk("R5 halt is one cycle", int'(halt_req), 0);
        recover(1'b0);
        chk("R7 no bor in mode 01", int'(flag_bor), 0);
        tick(); tick(); clear_all();

        // R7: mode 10
        enter_busoff(2'b10);
        recover(1'b0);
        chk("R7 bor set mode 10", int'(flag_bor), 1);
        tick(); tick(); clear_all();

        // R7: mode 11 without halt
        enter_busoff(2'b11);
        recover(1'b0);
        chk("R7 bor set mode 11", int'(flag_bor), 1);
        tick(); tick(); clear_all();

        // R9: mode 11 with halt during bus-off
        enter_busoff(2'b11);
        op_mode = 2'b10; tick(); op_mode = 2'b00;
        recover(1'b0);
        chk("R9 halt suppresses bor", int'(flag_bor), 0);
        chk("R10 active after exit", int'(err_state), 0);
        tick(); tick(); clear_all();

        // R8: force request
        enter_busoff(2'b00);
        repeat (20) tick();
        force_recover = 1; tick(); force_recover = 0; tec = 0;
        chk("R8 forced exit to active", int'(err_state), 0);
        chk("R8 no bor on force", int'(flag_bor), 0);
        chk("R10 cnt_clr on force", int'(cnt_clr), 1);
        tick(); tick(); clear_all();

        // R8: reset operating mode
        enter_busoff(2'b10);
        op_mode = 2'b01; tick(); op_mode = 2'b00; tec = 0;
        chk("R8 reset-mode exit", int'(err_state), 0);
        chk("R8 no bor on reset mode", int'(flag_bor), 0);
        tick(); tick(); clear_all();

        // R8: force coinciding with completion
        enter_busoff(2'b00);
        recover(1'b1);
        chk("R8 force wins over completion", int'(flag_bor), 0);
        tick();

        // R10: counters ignored the clock after exit
        enter_busoff(2'b00);
        force_recover = 1; tick(); force_recover = 0;
        tick();
        chk("R10 inputs ignored after exit", int'(err_state), 0);
        tec = 0; tick(); tick();
        chk("R1 settled active", int'(err_state), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #2000000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule